// File: doc/BRIEF.md
# Pulse Position Reader Frame Decoder

This block turns the reader-to-tag downlink of a proximity card link into bytes. It watches a one-bit pause detector (1 means the carrier is paused) that is sampled once per tick, where one tick is 32 carrier cycles. The opening pattern of each frame fixes the coding. The gap between the first two pauses picks either four slots per symbol (two bits per symbol) or 256 slots per symbol (one byte per symbol). In both codings a slot lasts 8 ticks. Each data pause sits in the second half of a slot, and the index of that slot is the symbol's value.

Bytes leave the block one at a time on a strobe. When the closing pause arrives, the block pulses a frame-done strobe and shows the number of bytes received. It also works out when the frame began by stepping back from the closing time: it subtracts the byte durations for the chosen coding and the fixed lengths of the opening and closing patterns. A reader-active flag tells neighbouring logic that a downlink frame is in progress. A tag-busy input holds the decoder idle while the local transmitter is sending.

Top module: `ppd_frame_decoder`

## Requirements
- R1: After reset, reader_active, frame_done and byte_valid are low and byte_count is zero.
- R2: A frame opens with a pause start while idle, followed by a second pause start. If the second pause starts 15 to 17 ticks after the first, the frame uses 4-slot coding. If it starts 23 to 25 ticks after the first, the frame uses 256-slot coding. A second pause at any other distance, or no second pause within 25 ticks, returns the decoder to idle.
- R3: In 4-slot coding, the first symbol starts 32 ticks after the first opening pause. Each symbol lasts 32 ticks. A pause starting at tick offset 4 to 7 of slot k (a slot is 8 ticks) gives the value k. Four symbols form one byte, least significant bit pair first.
- R4: In 256-slot coding, each symbol lasts 2048 ticks and is one byte, whose value is the index (0 to 255) of the slot holding the pause. The pause must start in the second half of that slot.
- R5: A pause starting in the first half of slot 0 of a symbol, at a byte boundary, closes the frame. frame_done then pulses 16 ticks after that symbol began, with byte_count equal to the number of bytes delivered. frame_done and byte_valid never pulse together.
- R6: At frame_done, start_time equals now_ticks at the closing tick, minus byte_count × 128 (4-slot coding) or × 2048 (256-slot coding), minus 48. For a well-formed frame this is the now_ticks value of the first opening pause.
- R7: reader_active goes high on the first opening pause and stays high until the frame closes or is dropped. Every frame_done follows a cycle with reader_active high.
- R8: The frame is dropped without frame_done in any of these cases: a pause starts in the first half of a slot other than the closing case, a second pause falls within one symbol, a symbol ends with no pause, or the closing pattern arrives in the middle of a byte.
- R9: If a byte completes while byte_count already equals MAX_BYTES, that byte is not delivered and the frame is dropped. byte_count never exceeds MAX_BYTES.
- R10: While tag_busy is high on a tick, the decoder stays idle, ignores pauses and keeps reader_active low.
- R11: Clock cycles with tick_en low change no state: pause_in is ignored, no strobe fires, and reader_active and byte_count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe marking each sample tick |
| pause_in | input | 1 | Sampled envelope, 1 = carrier paused |
| tag_busy | input | 1 | Local transmitter is sending; suppresses decoding |
| now_ticks | input | TIME_W | Current tick timestamp |
| byte_valid | output | 1 | One-cycle strobe for a decoded byte |
| byte_data | output | 8 | Decoded byte |
| frame_done | output | 1 | One-cycle strobe when a frame closes |
| byte_count | output | CNT_W | Bytes delivered in the current or last frame |
| start_time | output | TIME_W | Computed start timestamp of the last closed frame |
| reader_active | output | 1 | A downlink frame is being received |

## Verification
The bench sets MAX_BYTES to 4, so the overflow drop is reached with a five-byte frame. It keeps the 8-tick slot, so two-byte frames in 256-slot coding last only a few thousand ticks and slot 255 is within reach. The timing tolerance is left at one tick, so random opening gaps hit both edges of each window. In 4-slot frames the ticks are spaced by random idle cycles, during which pause_in is driven with noise.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF2,
        ST_SOFEND,
        ST_DATA,
        ST_EOF
    } ppd_state_e;
endpackage

// File: rtl/ppd_edge.sv
// Pause onset detector, advanced only on ticks.
module ppd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic pause_in,
    output logic pause_start
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prev_q <= 1'b0;
        else if (tick_en) prev_q <= pause_in;
    end

    assign pause_start = tick_en & pause_in & ~prev_q;
endmodule

// File: rtl/ppd_slot.sv
// Maps a symbol tick offset to slot index, half and end-of-symbol.
module ppd_slot #(
    parameter int SLOT_LG = 3,
    parameter int POS_W   = SLOT_LG + 8
) (
    input  logic [POS_W-1:0] pos,
    input  logic             long_mode,
    output logic [7:0]       slot_idx,
    output logic             late_half,
    output logic             sym_last
);
    localparam int SLOT_TICKS = 1 << SLOT_LG;
    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(4 * SLOT_TICKS - 1);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(256 * SLOT_TICKS - 1);

    assign slot_idx  = long_mode ? pos[SLOT_LG+7:SLOT_LG]
                                 : {6'd0, pos[SLOT_LG+1:SLOT_LG]};
    assign late_half = pos[SLOT_LG-1];
    assign sym_last  = long_mode ? (pos == LAST_LONG) : (pos == LAST_SHORT);
endmodule

// File: rtl/ppd_stamp.sv
// Back-computes the frame start timestamp from the closing time.
module ppd_stamp #(
    parameter int TIME_W     = 32,
    parameter int CNT_W      = 6,
    parameter int BYTE_SHORT = 128,
    parameter int BYTE_LONG  = 2048,
    parameter int FIXED      = 48
) (
    input  logic [TIME_W-1:0] now_ticks,
    input  logic [CNT_W-1:0]  count,
    input  logic              long_mode,
    output logic [TIME_W-1:0] start_time
);
    logic [TIME_W-1:0] span;

    always_comb begin
        span = TIME_W'(count) * (long_mode ? TIME_W'(BYTE_LONG) : TIME_W'(BYTE_SHORT));
        start_time = now_ticks - span - TIME_W'(FIXED);
    end
endmodule

// File: rtl/ppd_frame_decoder.sv
module ppd_frame_decoder
    import ppd_pkg::*;
#(
    parameter int SLOT_LG   = 3,
    parameter int MAX_BYTES = 32,
    parameter int TIME_W    = 32,
    parameter int SOF_TICKS = 32,
    parameter int EOF_TICKS = 16,
    parameter int SEP_SHORT = 16,
    parameter int SEP_LONG  = 24,
    parameter int SEP_TOL   = 1,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pause_in,
    input  logic              tag_busy,
    input  logic [TIME_W-1:0] now_ticks,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              frame_done,
    output logic [CNT_W-1:0]  byte_count,
    output logic [TIME_W-1:0] start_time,
    output logic              reader_active
);
    localparam int POS_W      = SLOT_LG + 8;
    localparam int SLOT_TICKS = 1 << SLOT_LG;
    localparam int BYTE_SHORT = 16 * SLOT_TICKS;
    localparam int BYTE_LONG  = 256 * SLOT_TICKS;
    localparam logic [POS_W-1:0] S_LO     = POS_W'(SEP_SHORT - SEP_TOL);
    localparam logic [POS_W-1:0] S_HI     = POS_W'(SEP_SHORT + SEP_TOL);
    localparam logic [POS_W-1:0] L_LO     = POS_W'(SEP_LONG - SEP_TOL);
    localparam logic [POS_W-1:0] L_HI     = POS_W'(SEP_LONG + SEP_TOL);
    localparam logic [POS_W-1:0] SOF_LAST = POS_W'(SOF_TICKS - 1);
    localparam logic [POS_W-1:0] EOF_AT   = POS_W'(EOF_TICKS);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BYTES);

    typedef struct packed {
        ppd_state_e        st;
        logic [POS_W-1:0]  pos;
        logic              long_m;
        logic              got;
        logic [7:0]        val;
        logic [1:0]        sub;
        logic [7:0]        shreg;
        logic [CNT_W-1:0]  cnt;
        logic              bv;
        logic [7:0]        bdata;
        logic              done;
        logic [TIME_W-1:0] tstart;
    } regs_t;

    regs_t r_q, r_d;

    logic              pstart;
    logic [7:0]        slot_idx;
    logic              late_half;
    logic              sym_last;
    logic [TIME_W-1:0] stamp;

    ppd_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .pause_in   (pause_in),
        .pause_start(pstart)
    );

    ppd_slot #(.SLOT_LG(SLOT_LG), .POS_W(POS_W)) u_slot (
        .pos      (r_q.pos),
        .long_mode(r_q.long_m),
        .slot_idx (slot_idx),
        .late_half(late_half),
        .sym_last (sym_last)
    );

    ppd_stamp #(
        .TIME_W    (TIME_W),
        .CNT_W     (CNT_W),
        .BYTE_SHORT(BYTE_SHORT),
        .BYTE_LONG (BYTE_LONG),
        .FIXED     (SOF_TICKS + EOF_TICKS)
    ) u_stamp (
        .now_ticks (now_ticks),
        .count     (r_q.cnt),
        .long_mode (r_q.long_m),
        .start_time(stamp)
    );

    logic       hit;
    logic [7:0] sym_v;
    logic [7:0] nb;
    logic       full;

    always_comb begin
        r_d     = r_q;
        r_d.bv  = 1'b0;
        r_d.done = 1'b0;
        hit     = pstart & late_half & ~r_q.got;
        sym_v   = hit ? slot_idx : r_q.val;
        nb      = r_q.long_m ? sym_v : {sym_v[1:0], r_q.shreg[7:2]};
        full    = r_q.long_m | (r_q.sub == 2'd3);
        if (tick_en) begin
            if (tag_busy) begin
                r_d.st = ST_IDLE;
            end else begin
                unique case (r_q.st)
                    ST_IDLE: begin
                        if (pstart) begin
                            r_d.st  = ST_SOF2;
                            r_d.pos = POS_W'(1);
                            r_d.cnt = '0;
                            r_d.got = 1'b0;
                            r_d.sub = 2'd0;
                        end
                    end
                    ST_SOF2: begin
                        r_d.pos = r_q.pos + POS_W'(1);
                        if (pstart) begin
                            if (r_q.pos >= S_LO && r_q.pos <= S_HI) begin
                                r_d.long_m = 1'b0;
                                r_d.st     = ST_SOFEND;
                            end else if (r_q.pos >= L_LO && r_q.pos <= L_HI) begin
                                r_d.long_m = 1'b1;
                                r_d.st     = ST_SOFEND;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.pos >= L_HI) begin
                            r_d.st = ST_IDLE;
                        end
                    end
                    ST_SOFEND: begin
                        r_d.pos = r_q.pos + POS_W'(1);
                        if (r_q.pos == SOF_LAST) begin
                            r_d.pos = '0;
                            r_d.st  = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        r_d.pos = r_q.pos + POS_W'(1);
                        if (pstart && late_half && r_q.got) begin
                            r_d.st = ST_IDLE;
                        end else if (pstart && !late_half) begin
                            if (slot_idx == 8'd0 && !r_q.got && r_q.sub == 2'd0)
                                r_d.st = ST_EOF;
                            else
                                r_d.st = ST_IDLE;
                        end else begin
                            if (hit) begin
                                r_d.got = 1'b1;
                                r_d.val = slot_idx;
                            end
                            if (sym_last) begin
                                if (!(r_q.got || hit)) begin
                                    r_d.st = ST_IDLE;
                                end else begin
                                    r_d.pos   = '0;
                                    r_d.got   = 1'b0;
                                    r_d.shreg = nb;
                                    if (!r_q.long_m) r_d.sub = r_q.sub + 2'd1;
                                    if (full) begin
                                        if (r_q.cnt == CNT_MAX) begin
                                            r_d.st = ST_IDLE;
                                        end else begin
                                            r_d.bv    = 1'b1;
                                            r_d.bdata = nb;
                                            r_d.cnt   = r_q.cnt + CNT_W'(1);
                                        end
                                    end
                                end
                            end
                        end
                    end
                    ST_EOF: begin
                        r_d.pos = r_q.pos + POS_W'(1);
                        if (r_q.pos == EOF_AT) begin
                            r_d.done   = 1'b1;
                            r_d.tstart = stamp;
                            r_d.st     = ST_IDLE;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid    = r_q.bv;
    assign byte_data     = r_q.bdata;
    assign frame_done    = r_q.done;
    assign byte_count    = r_q.cnt;
    assign start_time    = r_q.tstart;
    assign reader_active = (r_q.st != ST_IDLE);
endmodule

// File: rtl/ppd_frame_decoder_chk.sv
module ppd_frame_decoder_chk #(
    parameter int MAX_BYTES = 32,
    parameter int CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             tag_busy,
    input logic             byte_valid,
    input logic             frame_done,
    input logic [CNT_W-1:0] byte_count,
    input logic             reader_active
);
    assert_done_after_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(reader_active));

    assert_done_leaves_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !reader_active);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_done, byte_valid}));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CNT_W'(MAX_BYTES));

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> byte_count == $past(byte_count) + CNT_W'(1));

    assert_busy_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && tag_busy) |=> !reader_active);

    assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(reader_active) && $stable(byte_count) && !byte_valid && !frame_done));
endmodule

bind ppd_frame_decoder ppd_frame_decoder_chk #(
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .tag_busy     (tag_busy),
    .byte_valid   (byte_valid),
    .frame_done   (frame_done),
    .byte_count   (byte_count),
    .reader_active(reader_active)
);

// File: tb/ppd_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module ppd_frame_decoder_tb_top;
    localparam int MAXB = 4;
    localparam int CW   = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst_n, tick_en, pause_in, tag_busy;
    logic [31:0]   now_ticks;
    logic          byte_valid, frame_done, reader_active;
    logic [7:0]    byte_data;
    logic [CW-1:0] byte_count;
    logic [31:0]   start_time;

    always #2.5 clk = ~clk;

    ppd_frame_decoder #(.MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pause_in(pause_in),
        .tag_busy(tag_busy), .now_ticks(now_ticks), .byte_valid(byte_valid),
        .byte_data(byte_data), .frame_done(frame_done), .byte_count(byte_count),
        .start_time(start_time), .reader_active(reader_active)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor, sampled 1 ns after the rising edge
    int mn = 0, mdone_n = 0, mact_n = 0;
    logic [7:0]    mb [0:63];
    logic [CW-1:0] mcnt;
    logic [31:0]   mstart;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (byte_valid) begin mb[mn % 64] = byte_data; mn++; end
            if (frame_done) begin mdone_n++; mcnt = byte_count; mstart = start_time; end
            if (reader_active) mact_n++;
        end
    end

    int gap_max = 0;
    bit noise = 0;
    logic [31:0] tnow = 0;

    task automatic tk(bit p);
        int g;
        pause_in = p; tick_en = 1'b1; now_ticks = tnow;
        @(negedge clk);
        tick_en = 1'b0; tnow++;
        g = (gap_max > 0) ? int'($urandom_range(0, gap_max)) : 0;
        repeat (g) begin
            if (noise) pause_in = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        pause_in = p;
    endtask

    task automatic run(bit p, int n);
        for (int i = 0; i < n; i++) tk(p);
    endtask

    task automatic sof(int sep, output logic [31:0] t0);
        t0 = tnow;
        run(1, 3); run(0, sep - 3); run(1, 3); run(0, 32 - sep - 3);
    endtask

    task automatic sym4(int v);
        run(0, 8 * v + 4); run(1, 3); run(0, 25 - 8 * v);
    endtask

    task automatic sym256(int v);
        run(0, 8 * v + 4); run(1, 3); run(0, 2048 - 8 * v - 7);
    endtask

    task automatic eof();
        run(1, 3); run(0, 19);
    endtask

    task automatic send_byte(bit lng, logic [7:0] b);
        if (lng) sym256(int'(b));
        else for (int k = 0; k < 4; k++) sym4(int'((b >> (2 * k)) & 8'h03));
    endtask

    function automatic longint exp_start(logic [31:0] t0);
        return longint'(t0);
    endfunction

    task automatic check_frame(bit lng, int n, logic [7:0] bytes [8], int sep);
        int b0, d0;
        logic [31:0] t0;
        b0 = mn; d0 = mdone_n;
        sof(sep, t0);
        for (int i = 0; i < n; i++) send_byte(lng, bytes[i]);
        eof();
        chk(mdone_n == d0 + 1, "R5 frame_done pulses", mdone_n - d0, 1);
        chk(mcnt == CW'(n), "R5 byte_count at done", mcnt, n);
        chk(mn - b0 == n, lng ? "R4 byte strobes" : "R3 byte strobes", mn - b0, n);
        for (int i = 0; i < n; i++)
            chk(mb[(b0 + i) % 64] == bytes[i], lng ? "R4 byte value" : "R3 byte value",
                mb[(b0 + i) % 64], bytes[i]);
        chk(mstart == exp_start(t0), "R6 start_time", mstart, exp_start(t0));
        chk(!reader_active, "R7 inactive after frame", reader_active, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] bytes [8];
        logic [31:0] t0;
        int d0, a0, b0;
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; tick_en = 1'b0; pause_in = 1'b0; tag_busy = 1'b0; now_ticks = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!reader_active, "R1 reader_active", reader_active, 0);
        chk(!frame_done, "R1 frame_done", frame_done, 0);
        chk(!byte_valid, "R1 byte_valid", byte_valid, 0);
        chk(byte_count == 0, "R1 byte_count", byte_count, 0);
        run(0, 5);

        // R3 directed short frame
        bytes[0] = 8'hA5; bytes[1] = 8'h3C;
        check_frame(0, 2, bytes, 16);

        // R4 directed long frame, slot 255 and slot 0, window edge 25
        bytes[0] = 8'hFF; bytes[1] = 8'h00;
        check_frame(1, 2, bytes, 25);

        // R7 active from first pause
        d0 = mdone_n;
        run(1, 1);
        chk(reader_active, "R7 active after first pause", reader_active, 1);
        run(1, 2); run(0, 13); run(1, 3); run(0, 13);
        send_byte(0, 8'h5A); eof();
        chk(mdone_n == d0 + 1, "R7 frame closes", mdone_n - d0, 1);
        chk(!reader_active, "R7 low after done", reader_active, 0);

        // R2 out-of-window opening gap drops at once
        d0 = mdone_n;
        run(1, 3); run(0, 17); run(1, 1);
        chk(!reader_active, "R2 bad gap drops", reader_active, 0);
        run(1, 2); run(0, 40);
        chk(mdone_n == d0, "R2 no done on bad gap", mdone_n - d0, 0);

        // R8 pause in first half of slot 2
        d0 = mdone_n;
        sof(16, t0); run(0, 16); run(1, 1);
        chk(!reader_active, "R8 early-half pause drops", reader_active, 0);
        run(1, 2); run(0, 40);

        // R8 symbol without pause
        sof(16, t0); run(0, 32);
        chk(!reader_active, "R8 empty symbol drops", reader_active, 0);

        // R8 two pauses in one symbol
        sof(16, t0); run(0, 4); run(1, 3); run(0, 5); run(1, 1);
        chk(!reader_active, "R8 double pause drops", reader_active, 0);
        run(1, 2); run(0, 40);

        // R8 closing pattern mid byte
        sof(16, t0); sym4(1); sym4(2); eof(); run(0, 40);
        chk(mdone_n == d0, "R8 no done on bad frames", mdone_n - d0, 0);
        chk(!reader_active, "R8 idle after mid-byte close", reader_active, 0);

        // R9 overflow: five bytes with MAX_BYTES = 4
        d0 = mdone_n; b0 = mn;
        sof(16, t0);
        for (int i = 0; i < 5; i++) send_byte(0, 8'(i + 1));
        chk(mn - b0 == MAXB, "R9 bytes delivered before overflow", mn - b0, MAXB);
        chk(!reader_active, "R9 dropped on overflow", reader_active, 0);
        eof(); run(0, 40);
        chk(mdone_n == d0, "R9 no done", mdone_n - d0, 0);

        // R10 tag busy suppresses decoding
        d0 = mdone_n; a0 = mact_n;
        tag_busy = 1'b1;
        sof(16, t0); send_byte(0, 8'h77); eof();
        tag_busy = 1'b0;
        run(0, 10);
        chk(mact_n == a0, "R10 never active while busy", mact_n - a0, 0);
        chk(mdone_n == d0, "R10 no done while busy", mdone_n - d0, 0);

        // random frames; gapped ticks with noise cover R11
        for (int f = 0; f < 10; f++) begin
            bit lng;
            int n, sep;
            lng = (f % 5 == 4);
            n = lng ? int'($urandom_range(1, 2)) : int'($urandom_range(1, MAXB));
            for (int i = 0; i < 8; i++) bytes[i] = 8'($urandom);
            sep = (lng ? 24 : 16) + int'($urandom_range(0, 2)) - 1;
            gap_max = lng ? 0 : int'($urandom_range(0, 2));
            noise = (gap_max > 0);
            check_frame(lng, n, bytes, sep);
            gap_max = 0; noise = 0;
            run(0, 4);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule